// File: doc/BRIEF.md
# Programmable-Butterfly Bit Permuter

This unit transforms a 64-bit word through six butterfly rows. Row k connects each bit with the bit whose index differs only in position k, which is a distance of 2^k. A row takes part only when bit k of a shift-amount operand is set. Inside an enabled row, each output bit is a 2-input lookup of its own bit and its partner bit. Two 4-bit tables are taken from an 8-bit control byte. The bit of a pair with the lower index reads the low table, and the bit with the higher index reads the high table. With suitable table bytes, one datapath gives generalised bit reversal, generalised OR-combine, XOR folding and a large family of regular constant masks.

The starting word is either the register operand or a fixed alternating pattern, selected by an external "source is zero" flag. An invert flag can complement the starting word before the first row. Instruction decode stays outside the block.

The interface carries no back-pressure. Each cycle with `in_valid` high is accepted. Its result appears on `out_data` one clock later, marked by `out_valid`. The result register holds its value until the next accepted operation.

Top module: `bfly_lut_unit`

## Requirements
- R1: When `src_zero` is 1, the starting word is 0x5555_5555_5555_5555, so bit j is 1 for every even j, and `src_data` is ignored.
- R2: When `invert` is 1, the starting word is the bitwise complement of the value chosen under R1. A zero source with invert therefore starts from 0xAAAA_AAAA_AAAA_AAAA.
- R3: A shift amount whose low 6 bits are all zero returns the starting word unchanged.
- R4: Row k (k = 0..5, distance 2^k) runs only when `shamt[k]` is 1, and the rows run in increasing k.
- R5: In a row of distance c, with s = bit j and p = bit j^c of the row input: if (j & c) == 0, out[j] = tbl[{s,p}]; otherwise out[j] = tbl[4 + {p,s}], where `{x,y}` is the 2-bit index x*2+y.
- R6: With tbl = 0xCA, the result bit j equals start bit (j XOR shamt[5:0]), which is a pure generalised reverse.
- R7: With tbl = 0xEE, each enabled row ORs every bit with its partner (generalised OR-combine).
- R8: The alternating start with invert 0 and tbl 0x6C gives 0x1111…, 0x0101… and 0x0001_0001… for shamt 0b10, 0b110 and 0b1110. With invert 1 and tbl 0xC6, the same shift amounts give 0x8888…, 0x8080… and 0x8000_8000….
- R9: Bits of `shamt` above bit 5 have no effect on the result.
- R10: `out_valid` is `in_valid` delayed by one clock. `out_data` is loaded only on an accepted cycle and otherwise holds. Reset clears both to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation accepted this cycle |
| src_data | input | 64 | Register operand used as the start word |
| src_zero | input | 1 | Use the alternating constant instead of src_data |
| invert | input | 1 | Complement the start word |
| shamt | input | 8 | Row enables; only bits 5:0 are used |
| tbl | input | 8 | Lookup tables: [3:0] lower-index bit, [7:4] higher-index bit |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_data | output | 64 | Registered result |

## Verification
The bench checks the six mask constants bit-exactly. A design that swapped the two table halves, or used one operand order for both halves, gives 0x4444… or other wrong patterns here, and the reverse byte stops acting as a swap. Reverse and OR-combine are compared against index formulas for many shift amounts: a row order or a partner distance that is off produces a mismatched permutation. Other checks cover the constant and inverted starts, shift bits above 5 (a design that decodes them would alter the result), shift amount zero, and a held result while in_valid is low (a register that loads every cycle would follow the idle inputs).

// File: rtl/bfly_lut_pkg.sv
package bfly_lut_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned TBL_W  = 8;

  // Pick one entry of a 4-entry truth table by a 2-bit index {hi,lo}.
  function automatic logic pick4(input logic [3:0] nib, input logic hi, input logic lo);
    return nib[{hi, lo}];
  endfunction
endpackage

// File: rtl/bfly_lut_seed.sv
module bfly_lut_seed #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] src_data,
  input  logic         src_zero,
  input  logic         invert,
  output logic [W-1:0] seed
);
  localparam logic [W-1:0] ALT = {(W/2){2'b01}};

  logic [W-1:0] base;
  always_comb begin
    base = src_zero ? ALT : src_data;
    seed = base ^ {W{invert}};
  end
endmodule

// File: rtl/bfly_lut_row.sv
module bfly_lut_row #(
  parameter int unsigned W    = 64,
  parameter int unsigned DIST = 1
) (
  input  logic [W-1:0] din,
  input  logic         en,
  input  logic [7:0]   tbl,
  output logic [W-1:0] dout
);
  import bfly_lut_pkg::*;

  logic [W-1:0] mixed;

  for (genvar j = 0; j < W; j++) begin : g_bit
    localparam int unsigned PART = j ^ DIST;
    if ((j & DIST) == 0) begin : g_lo
      // lower-index bit of the pair: own bit selects the upper index bit
      assign mixed[j] = pick4(tbl[3:0], din[j], din[PART]);
    end else begin : g_hi
      // higher-index bit: operand order swapped
      assign mixed[j] = pick4(tbl[7:4], din[PART], din[j]);
    end
  end

  assign dout = en ? mixed : din;

  // R4: a disabled row is transparent
  always_comb begin
    p_row_bypass_r4: assert (en !== 1'b0 || dout === din);
  end
endmodule

// File: rtl/bfly_lut_unit.sv
module bfly_lut_unit #(
  parameter int unsigned DATA_W  = bfly_lut_pkg::WORD_W,
  parameter int unsigned SHAMT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_zero,
  input  logic              invert,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [7:0]        tbl,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int unsigned   STAGES = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] ALT = {(DATA_W/2){2'b01}};

  logic [DATA_W-1:0] seed;
  logic [DATA_W-1:0] chain [0:STAGES];
  logic [STAGES-1:0] row_en;

  assign row_en = shamt[STAGES-1:0];

  bfly_lut_seed #(.W(DATA_W)) u_seed (
    .src_data (src_data),
    .src_zero (src_zero),
    .invert   (invert),
    .seed     (seed)
  );

  assign chain[0] = seed;

  for (genvar k = 0; k < STAGES; k++) begin : g_row
    bfly_lut_row #(.W(DATA_W), .DIST(1 << k)) u_row (
      .din  (chain[k]),
      .en   (row_en[k]),
      .tbl  (tbl),
      .dout (chain[k+1])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= chain[STAGES];
    end
  end

  p_valid_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  p_const_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && src_zero && !invert && row_en == '0) |=> out_data == ALT);

  p_zero_shamt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && row_en == '0) |=> out_data == $past(seed));

  p_reverse_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && tbl == 8'hCA) |=> $countones(out_data) == $countones($past(seed)));

  p_orcomb_cover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && tbl == 8'hEE) |=> (out_data & $past(seed)) == $past(seed));
endmodule

// File: tb/bfly_lut_unit_test.sv
module bfly_lut_unit_test;
  localparam int W = 64;
  localparam logic [W-1:0] ALT = {(W/2){2'b01}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] src_data = '0;
  logic         src_zero = 1'b0;
  logic         invert = 1'b0;
  logic [7:0]   shamt = '0;
  logic [7:0]   tbl = '0;
  logic         out_valid;
  logic [W-1:0] out_data;

  int total = 0;
  int bad = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #2 clk = ~clk;

  bfly_lut_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_data(src_data),
    .src_zero(src_zero), .invert(invert), .shamt(shamt), .tbl(tbl),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [63:0] next_rnd(input logic [63:0] s);
    logic [63:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  // Expected value from R1, R2, R4, R5
  function automatic logic [W-1:0] model(input logic [W-1:0] s, input logic z,
      input logic inv, input logic [7:0] sh, input logic [7:0] t);
    logic [W-1:0] x, y;
    x = z ? ALT : s;
    if (inv) x = ~x;
    for (int k = 0; k < 6; k++) begin
      if (sh[k]) begin
        for (int j = 0; j < W; j++) begin
          int p = j ^ (1 << k);
          if ((j & (1 << k)) == 0) y[j] = t[{x[j], x[p]}];
          else                      y[j] = t[4 + int'({x[p], x[j]})];
        end
        x = y;
      end
    end
    return x;
  endfunction

  function automatic logic [W-1:0] grev_ref(input logic [W-1:0] x, input logic [5:0] sh);
    logic [W-1:0] r;
    for (int j = 0; j < W; j++) r[j] = x[j ^ int'(sh)];
    return r;
  endfunction

  function automatic logic [W-1:0] gorc_ref(input logic [W-1:0] x, input logic [5:0] sh);
    logic [W-1:0] r = x;
    for (int k = 0; k < 6; k++)
      if (sh[k]) r = r | grev_ref(r, 6'(1 << k));
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic run_op(input logic [W-1:0] s, input logic z, input logic inv,
      input logic [7:0] sh, input logic [7:0] t, output logic [W-1:0] res);
    @(negedge clk);
    src_data = s; src_zero = z; invert = inv; shamt = sh; tbl = t; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    res = out_data;
    total++;
    if (out_valid !== 1'b1) begin
      bad++;
      $display("FAIL R10: out_valid got=%b expected=1", out_valid);
    end
  endtask

  task automatic t_reset;
    check("R10 reset data", out_data, '0);
    check("R10 reset valid", {63'd0, out_valid}, '0);
  endtask

  task automatic t_const_start;
    logic [W-1:0] r;
    run_op(64'hDEAD_BEEF_0123_4567, 1'b1, 1'b0, 8'h00, 8'hCA, r);
    check("R1 constant start", r, 64'h5555_5555_5555_5555);
  endtask

  task automatic t_invert;
    logic [W-1:0] r;
    run_op(64'h0, 1'b1, 1'b1, 8'h00, 8'h00, r);
    check("R2 inverted constant", r, 64'hAAAA_AAAA_AAAA_AAAA);
    run_op(64'h0123_4567_89AB_CDEF, 1'b0, 1'b1, 8'h00, 8'h00, r);
    check("R2 inverted operand", r, 64'hFEDC_BA98_7654_3210);
  endtask

  task automatic t_zero_shamt;
    logic [W-1:0] r;
    run_op(64'hC0FF_EE00_1234_5678, 1'b0, 1'b0, 8'h00, 8'h6C, r);
    check("R3 zero shift passthrough", r, 64'hC0FF_EE00_1234_5678);
  endtask

  task automatic t_table;
    logic [W-1:0] r;
    run_op('0, 1'b1, 1'b0, 8'b10, 8'h6C, r);   check("R8 mask 0x11", r, 64'h1111_1111_1111_1111);
    run_op('0, 1'b1, 1'b0, 8'b110, 8'h6C, r);  check("R8 mask 0x01", r, 64'h0101_0101_0101_0101);
    run_op('0, 1'b1, 1'b0, 8'b1110, 8'h6C, r); check("R8 mask 0x0001", r, 64'h0001_0001_0001_0001);
    run_op('0, 1'b1, 1'b1, 8'b10, 8'hC6, r);   check("R8 mask 0x88", r, 64'h8888_8888_8888_8888);
    run_op('0, 1'b1, 1'b1, 8'b110, 8'hC6, r);  check("R8 mask 0x80", r, 64'h8080_8080_8080_8080);
    run_op('0, 1'b1, 1'b1, 8'b1110, 8'hC6, r); check("R8 mask 0x8000", r, 64'h8000_8000_8000_8000);
  endtask

  task automatic t_reverse;
    logic [W-1:0] r;
    for (int i = 0; i < 8; i++) begin
      logic [5:0] sh;
      rng = next_rnd(rng);
      sh = (i == 7) ? 6'd63 : rng[37:32];
      run_op(rng, 1'b0, 1'b0, {2'b00, sh}, 8'hCA, r);
      check("R6 generalised reverse", r, grev_ref(rng, sh));
    end
  endtask

  task automatic t_orcomb;
    logic [W-1:0] r;
    for (int i = 0; i < 6; i++) begin
      logic [5:0] sh;
      rng = next_rnd(rng);
      sh = 6'(1 << i) | rng[45:40];
      run_op(rng & next_rnd(rng), 1'b0, 1'b0, {2'b00, sh}, 8'hEE, r);
      check("R7 OR-combine", r, gorc_ref(rng & next_rnd(rng), sh));
    end
  endtask

  task automatic t_single_rows;
    logic [W-1:0] r;
    // One row at a time with an asymmetric table checks R4 distances and R5 halves.
    for (int k = 0; k < 6; k++) begin
      rng = next_rnd(rng);
      run_op(rng, 1'b0, 1'b0, 8'(1 << k), 8'h4B, r);
      check("R5 single row lookup", r, model(rng, 1'b0, 1'b0, 8'(1 << k), 8'h4B));
    end
    for (int i = 0; i < 10; i++) begin
      logic [7:0] t;
      rng = next_rnd(rng);
      t = rng[55:48];
      run_op(rng, rng[3], rng[9], {2'b00, rng[21:16]}, t, r);
      check("R4 ordered rows", r, model(rng, rng[3], rng[9], {2'b00, rng[21:16]}, t));
    end
  endtask

  task automatic t_high_shamt;
    logic [W-1:0] r1, r2;
    run_op(64'h0F1E_2D3C_4B5A_6978, 1'b0, 1'b0, 8'h05, 8'h9D, r1);
    run_op(64'h0F1E_2D3C_4B5A_6978, 1'b0, 1'b0, 8'hC5, 8'h9D, r2);
    check("R9 upper shift bits ignored", r2, r1);
    run_op(64'h0F1E_2D3C_4B5A_6978, 1'b0, 1'b0, 8'hC0, 8'h9D, r2);
    check("R9 upper-only shift is identity", r2, 64'h0F1E_2D3C_4B5A_6978);
  endtask

  task automatic t_hold;
    logic [W-1:0] r;
    run_op(64'h1357_9BDF_2468_ACE0, 1'b0, 1'b0, 8'h00, 8'hCA, r);
    @(negedge clk);
    src_data = 64'hFFFF_0000_FFFF_0000; shamt = 8'h3F; tbl = 8'hEE;
    repeat (3) @(negedge clk);
    check("R10 result holds while idle", out_data, 64'h1357_9BDF_2468_ACE0);
    check("R10 valid drops", {63'd0, out_valid}, '0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_const_start();
    t_invert();
    t_zero_shamt();
    t_table();
    t_reverse();
    t_orcomb();
    t_single_rows();
    t_high_shamt();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule